// File: doc/BRIEF.md
# Task Register Descriptor Loader

This block loads a task-segment selector into the task register of a processor core. The register has two parts. One is the selector, which software can see. The other is a hidden cache that holds the descriptor attributes, an expanded 32-bit limit and a base address. When a load is requested, the block checks the selector against the descriptor table. It then reads the descriptor from memory, one 32-bit word at a time, over a request port with a valid/ready handshake. It validates the descriptor type and writes the descriptor word back with the busy flag set. Finally it commits the selector and the cached fields in a single cycle.

The descriptor size depends on the mode latched at the request. In 64-bit mode the descriptor is 16 bytes and the full 64-bit base is filled. In legacy mode the descriptor is 8 bytes and only the low 32 base bits are loaded. When the base is presented while the core is in legacy mode, the upper half is forced to zero. The block never touches the task-state segment and never starts a task switch. It signals either a one-cycle completion or a one-cycle fault.

Top module: `tr_loader`

## Requirements
- R1: After reset, the selector, base, limit, attributes, `done`, `fault`, `mem_valid` and `ld_busy` are all zero.
- R2: The descriptor is read at consecutive word addresses, starting at `gdt_base + load_sel[15:3]*8` and rising by 4.
- R3: A legacy-mode load reads exactly 2 words. It loads base `{w1[31:24], w1[7:0], w0[31:16]}` with the upper 32 bits zero.
- R4: A 64-bit-mode load reads exactly 4 words. Word 2 supplies base bits [63:32], and the content of word 3 has no effect.
- R5: The limit is the 20-bit value `{w1[19:16], w0[15:0]}`. When `w1[23]` is set, the limit is shifted left by 12 and filled with ones.
- R6: A selector with bit 2 set raises `fault`. It makes no memory access and leaves the task register unchanged.
- R7: If `sel*8 + 7` (legacy) or `sel*8 + 15` (64-bit) is greater than `gdt_limit`, the block raises `fault`. It makes no memory access and leaves the register unchanged.
- R8: Only `w1[12:8] == 5'b01001` is accepted, meaning a system descriptor of the available task type. Any other value raises `fault`, makes no write, and leaves both the register and memory unchanged.
- R9: A successful load makes exactly one write. The write goes to the address of word 1 and carries word 1 with bit 9 (busy) set. No other address is accessed.
- R10: `done` pulses for one cycle and the new register contents appear in that same cycle. `done` and `fault` are never high together.
- R11: `tr_attr` is `{w1[23:20], w1[15:10], 1, w1[8]}`, so the busy type is cached. `tr_base[63:32]` reads zero whenever `long_mode` is low, even if a full base is stored.
- R12: A `load_req` that arrives while `ld_busy` is high is ignored.
- R13: While `mem_valid` is high and `mem_ready` is low, the request stays asserted with a stable address and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_req | input | 1 | Start a load with `load_sel` |
| load_sel | input | 16 | Selector to load |
| long_mode | input | 1 | Core is in 64-bit mode |
| gdt_base | input | AW | Byte address of the descriptor table |
| gdt_limit | input | 16 | Last valid byte offset in the table |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Load completed |
| fault | output | 1 | Load rejected |
| ld_busy | output | 1 | A load is in progress |
| tr_sel | output | 16 | Visible selector |
| tr_base | output | 64 | Cached base, upper half masked in legacy mode |
| tr_limit | output | 32 | Cached expanded limit |
| tr_attr | output | 12 | Cached attributes |

## Verification
The bench sweeps selectors in both modes at full and half memory speed. The limit check is driven to the exact boundary, where one byte decides the outcome and the same index passes in legacy mode but fails in 64-bit mode. A design that used one fixed descriptor length would fail or accept the wrong side of that boundary, or it would read a word too few or too many. Rejected type codes and the table-indicator bit are checked for silent corruption: a design that wrote back or committed before the type check would leave a changed word 1 or a changed register. A base captured in 64-bit mode is viewed again after the mode drops, which catches a design that fails to mask the upper half. A second request issued mid-load catches a design that restarts on it.

// File: rtl/tr_ld_pkg.sv
package tr_ld_pkg;
  localparam int WORD_W = 32;
  localparam int BUSY_BIT = 9;
  // {S, type} for an available task-segment descriptor
  localparam logic [4:0] AVAIL_TSS = 5'b01001;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_CHECK, ST_WRITE} ld_state_t;

  function automatic logic [63:0] pick_base(input logic [31:0] lo_w, input logic [31:0] hi_w,
                                            input logic [31:0] ext_w, input logic wide);
    return {(wide ? ext_w : 32'h0), hi_w[31:24], hi_w[7:0], lo_w[31:16]};
  endfunction

  function automatic logic [31:0] pick_limit(input logic [31:0] lo_w, input logic [31:0] hi_w);
    logic [19:0] raw;
    raw = {hi_w[19:16], lo_w[15:0]};
    return hi_w[23] ? {raw, 12'hFFF} : {12'h000, raw};
  endfunction

  function automatic logic [11:0] pick_attr(input logic [31:0] hi_w);
    return {hi_w[23:20], hi_w[15:10], 1'b1, hi_w[8]};
  endfunction
endpackage

// File: rtl/tr_ld_selchk.sv
module tr_ld_selchk #(
  parameter int SEL_W = 16,
  parameter int LIM_W = 16
) (
  input  logic [SEL_W-3:0] sel_hi,
  input  logic             wide,
  input  logic [LIM_W-1:0] tbl_limit,
  output logic [SEL_W-1:0] offset,
  output logic             sel_fault
);
  localparam int CW = ((SEL_W > LIM_W) ? SEL_W : LIM_W) + 1;

  logic [CW-1:0] last_byte;
  logic          ti_bit;

  assign ti_bit    = sel_hi[0];
  assign offset    = {sel_hi[SEL_W-3:1], 3'b000};
  assign last_byte = CW'(offset) + (wide ? CW'(15) : CW'(7));
  assign sel_fault = ti_bit || (last_byte > CW'(tbl_limit));
endmodule

// File: rtl/tr_ld_seq.sv
module tr_ld_seq
  import tr_ld_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_wide,
  input  logic [AW-1:0]     start_addr,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] w0,
  output logic [WORD_W-1:0] w1,
  output logic [WORD_W-1:0] w2,
  output logic              wide,
  output logic              commit,
  output logic              type_fault,
  output logic              busy
);
  localparam logic [AW-1:0] STEP = AW'(4);

  ld_state_t     state;
  logic [1:0]    cnt;
  logic [1:0]    last;
  logic [AW-1:0] base_q;

  assign last = wide ? 2'd3 : 2'd1;
  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      mem_valid  <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      cnt        <= '0;
      base_q     <= '0;
      wide       <= 1'b0;
      w0         <= '0;
      w1         <= '0;
      w2         <= '0;
      commit     <= 1'b0;
      type_fault <= 1'b0;
    end else begin
      commit     <= 1'b0;
      type_fault <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_READ;
            mem_valid <= 1'b1;
            mem_we    <= 1'b0;
            mem_addr  <= start_addr;
            base_q    <= start_addr;
            wide      <= start_wide;
            cnt       <= 2'd0;
          end
        end
        ST_READ: begin
          if (mem_ready) begin
            case (cnt)
              2'd0:    w0 <= mem_rdata;
              2'd1:    w1 <= mem_rdata;
              2'd2:    w2 <= mem_rdata;
              default: ;
            endcase
            if (cnt == last) begin
              mem_valid <= 1'b0;
              state     <= ST_CHECK;
            end else begin
              cnt      <= cnt + 2'd1;
              mem_addr <= mem_addr + STEP;
            end
          end
        end
        ST_CHECK: begin
          if (w1[12:8] == AVAIL_TSS) begin
            mem_valid <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= base_q + STEP;
            mem_wdata <= w1 | (WORD_W'(1) << BUSY_BIT);
            state     <= ST_WRITE;
          end else begin
            type_fault <= 1'b1;
            state      <= ST_IDLE;
          end
        end
        ST_WRITE: begin
          if (mem_ready) begin
            mem_valid <= 1'b0;
            mem_we    <= 1'b0;
            commit    <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R13
  hold_req_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

  // R8
  write_type_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_we) |-> (w1[12:8] == AVAIL_TSS));

  // R9
  commit_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    commit |-> $past(mem_valid && mem_we && mem_ready));

  // R3
  read_count_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_READ && !wide) |-> (cnt <= 2'd1));
endmodule

// File: rtl/tr_ld_hold.sv
module tr_ld_hold #(
  parameter int SEL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit,
  input  logic [SEL_W-1:0] new_sel,
  input  logic [63:0]      new_base,
  input  logic [31:0]      new_limit,
  input  logic [11:0]      new_attr,
  input  logic             long_mode,
  output logic [SEL_W-1:0] tr_sel,
  output logic [63:0]      tr_base,
  output logic [31:0]      tr_limit,
  output logic [11:0]      tr_attr
);
  logic [63:0] base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tr_sel   <= '0;
      base_q   <= '0;
      tr_limit <= '0;
      tr_attr  <= '0;
    end else if (commit) begin
      tr_sel   <= new_sel;
      base_q   <= new_base;
      tr_limit <= new_limit;
      tr_attr  <= new_attr;
    end
  end

  assign tr_base = {(long_mode ? base_q[63:32] : 32'h0), base_q[31:0]};
endmodule

// File: rtl/tr_loader.sv
module tr_loader
  import tr_ld_pkg::*;
#(
  parameter int AW    = 32,
  parameter int SEL_W = 16,
  parameter int LIM_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_req,
  input  logic [SEL_W-1:0]  load_sel,
  input  logic              long_mode,
  input  logic [AW-1:0]     gdt_base,
  input  logic [LIM_W-1:0]  gdt_limit,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              done,
  output logic              fault,
  output logic              ld_busy,
  output logic [SEL_W-1:0]  tr_sel,
  output logic [63:0]       tr_base,
  output logic [31:0]       tr_limit,
  output logic [11:0]       tr_attr
);
  logic [SEL_W-1:0]  offset;
  logic              sel_fault;
  logic              go;
  logic              start;
  logic [SEL_W-1:0]  sel_q;
  logic [WORD_W-1:0] w0, w1, w2;
  logic              wide;
  logic              commit;
  logic              type_fault;

  tr_ld_selchk #(.SEL_W(SEL_W), .LIM_W(LIM_W)) u_chk (
    .sel_hi    (load_sel[SEL_W-1:2]),
    .wide      (long_mode),
    .tbl_limit (gdt_limit),
    .offset    (offset),
    .sel_fault (sel_fault)
  );

  assign go    = load_req && !ld_busy;
  assign start = go && !sel_fault;

  tr_ld_seq #(.AW(AW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_wide (long_mode),
    .start_addr (gdt_base + AW'(offset)),
    .mem_valid  (mem_valid),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ready  (mem_ready),
    .mem_rdata  (mem_rdata),
    .w0         (w0),
    .w1         (w1),
    .w2         (w2),
    .wide       (wide),
    .commit     (commit),
    .type_fault (type_fault),
    .busy       (ld_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      done  <= 1'b0;
      fault <= 1'b0;
    end else begin
      done  <= commit;
      fault <= (go && sel_fault) || type_fault;
      if (start) sel_q <= load_sel;
    end
  end

  tr_ld_hold #(.SEL_W(SEL_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .commit    (commit),
    .new_sel   (sel_q),
    .new_base  (pick_base(w0, w1, w2, wide)),
    .new_limit (pick_limit(w0, w1)),
    .new_attr  (pick_attr(w1)),
    .long_mode (long_mode),
    .tr_sel    (tr_sel),
    .tr_base   (tr_base),
    .tr_limit  (tr_limit),
    .tr_attr   (tr_attr)
  );

  // R10
  done_fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && fault));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  tr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(tr_sel) && $stable(tr_limit) && $stable(tr_attr)));

  // R11
  legacy_mask_chk: assert property (@(posedge clk) disable iff (rst)
    !long_mode |-> (tr_base[63:32] == 32'h0));
endmodule

// File: tb/sim_tr_loader.sv
`timescale 1ns/1ps
module sim_tr_loader;
  localparam int AW = 32;
  localparam logic [31:0] GDT_BASE = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_req = 1'b0;
  logic [15:0] load_sel = '0;
  logic        long_mode = 1'b0;
  logic [31:0] gdt_base = GDT_BASE;
  logic [15:0] gdt_limit = 16'h00FF;
  logic        mem_valid, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done, fault, ld_busy;
  logic [15:0] tr_sel;
  logic [63:0] tr_base;
  logic [31:0] tr_limit;
  logic [11:0] tr_attr;

  tr_loader #(.AW(AW)) u0 (
    .clk(clk), .rst(rst), .load_req(load_req), .load_sel(load_sel),
    .long_mode(long_mode), .gdt_base(gdt_base), .gdt_limit(gdt_limit),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .done(done), .fault(fault), .ld_busy(ld_busy), .tr_sel(tr_sel),
    .tr_base(tr_base), .tr_limit(tr_limit), .tr_attr(tr_attr)
  );

  always #2.5 clk = ~clk;

  logic [31:0] mem [64];
  int  tests = 0, fails = 0;
  int  n_rd = 0, n_wr = 0, n_bad = 0;
  int  win_lo = 0, win_hi = 0;
  bit  slow = 1'b0, ph = 1'b0;
  logic [31:0] last_waddr = '0;

  function automatic int widx(input logic [31:0] a);
    return int'((a - GDT_BASE) >> 2);
  endfunction

  always @(negedge clk) begin
    ph = ~ph;
    mem_ready = mem_valid && (!slow || ph);
    mem_rdata = (widx(mem_addr) >= 0 && widx(mem_addr) < 64) ? mem[widx(mem_addr)] : 32'hDEAD_BEEF;
  end

  always @(posedge clk) begin
    if (!rst && mem_valid && mem_ready) begin
      if (int'(mem_addr) < win_lo || int'(mem_addr) >= win_hi) n_bad <= n_bad + 1;
      if (mem_we) begin
        n_wr <= n_wr + 1;
        last_waddr <= mem_addr;
        if (widx(mem_addr) >= 0 && widx(mem_addr) < 64) mem[widx(mem_addr)] <= mem_wdata;
      end else n_rd <= n_rd + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_w1(input logic [63:0] b, input logic [19:0] lim,
                                        input bit g, input logic [4:0] typ);
    return {b[31:24], g, 1'b1, 1'b0, 1'b0, lim[19:16], 1'b1, 2'b00, typ, b[23:16]};
  endfunction

  task automatic put_desc(input int idx, input logic [63:0] b, input logic [19:0] lim,
                          input bit g, input logic [4:0] typ);
    mem[2*idx]   = {b[15:0], lim[15:0]};
    mem[2*idx+1] = mk_w1(b, lim, g, typ);
    mem[2*idx+2] = b[63:32];
    mem[2*idx+3] = 32'hFFFF_FFFF;
  endtask

  bit got_done, got_fault;

  task automatic run_load(input logic [15:0] sel, input bit lm, input bit spur);
    @(negedge clk);
    n_rd = 0; n_wr = 0; n_bad = 0;
    win_lo = int'(GDT_BASE) + int'(sel[15:3]) * 8;
    win_hi = win_lo + (lm ? 16 : 8);
    long_mode = lm; load_sel = sel; load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
    if (spur) begin
      load_sel = sel ^ 16'h0008; load_req = 1'b1;
      @(negedge clk);
      load_req = 1'b0;
    end
    got_done = 1'b0; got_fault = 1'b0;
    for (int k = 0; k < 200; k++) begin
      if (done || fault) break;
      @(negedge clk);
    end
    got_done = done; got_fault = fault;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 sel", tr_sel, 0); chk("R1 base", tr_base, 0);
    chk("R1 limit", tr_limit, 0); chk("R1 attr", tr_attr, 0);
    chk("R1 flags", {done, fault, mem_valid, ld_busy}, 0);
    rst = 1'b0;

    // R2 R3 R4 R5 R9 R10 R11 sweep
    for (int s = 0; s < 2; s++) begin
      for (int lm = 0; lm < 2; lm++) begin
        for (int i = 1; i <= 7; i++) begin
          int idx;
          logic [63:0] b;
          logic [19:0] lim;
          bit g;
          logic [63:0] eb;
          logic [31:0] el;
          slow = bit'(s);
          idx = lm ? 2 * i : i + 8 * s;
          b = {32'hC0DE_0000 | 32'(i), 32'h1357_9BDF ^ (32'(i) * 32'h0110_2203)};
          lim = 20'(i * 20'h2345 + lm);
          g = bit'(i & 1) ^ bit'(lm);
          put_desc(idx, b, lim, g, 5'b01001);
          run_load({13'(idx), 1'b0, 2'(i)}, bit'(lm), 1'b0);
          eb = lm ? b : {32'h0, b[31:0]};
          el = g ? {lim, 12'hFFF} : {12'h0, lim};
          chk("R10 done", {got_done, got_fault}, 2'b10);
          chk("R10 sel", tr_sel, {13'(idx), 1'b0, 2'(i)});
          chk(lm ? "R4 base" : "R3 base", tr_base, eb);
          chk("R5 limit", tr_limit, el);
          chk("R11 attr", tr_attr, {g, 1'b1, 2'b00, 1'b1, 2'b00, 1'b0, 4'b1011});
          chk(lm ? "R4 reads" : "R3 reads", n_rd, lm ? 4 : 2);
          chk("R9 writes", n_wr, 1);
          chk("R2 window", n_bad, 0);
          chk("R9 waddr", last_waddr, GDT_BASE + 32'(idx * 8 + 4));
          chk("R9 busy word", mem[2*idx+1], mk_w1(b, lim, g, 5'b01011));
          @(negedge clk);
          chk("R10 pulse", done, 0);
        end
      end
    end
    slow = 1'b0;

    // R11 full base masked when mode drops
    put_desc(4, 64'hFEDC_BA98_7654_3210, 20'h00010, 1'b0, 5'b01001);
    run_load(16'h0020, 1'b1, 1'b0);
    chk("R11 long base", tr_base, 64'hFEDC_BA98_7654_3210);
    @(negedge clk); long_mode = 1'b0;
    @(negedge clk);
    chk("R11 legacy view", tr_base, 64'h0000_0000_7654_3210);
    long_mode = 1'b1;
    @(negedge clk);
    chk("R11 restored", tr_base, 64'hFEDC_BA98_7654_3210);

    // R8 rejected types
    for (int t = 0; t < 3; t++) begin
      logic [4:0] typ;
      logic [15:0] s0;
      logic [63:0] b0;
      typ = (t == 0) ? 5'b01011 : (t == 1) ? 5'b11001 : 5'b00001;
      s0 = tr_sel; b0 = tr_base;
      put_desc(10, 64'h1111_2222_3333_4444, 20'h00ABC, 1'b0, typ);
      run_load(16'h0050, 1'b0, 1'b0);
      chk("R8 fault", {got_done, got_fault}, 2'b01);
      chk("R8 no write", n_wr, 0);
      chk("R8 mem kept", mem[21], mk_w1(64'h1111_2222_3333_4444, 20'h00ABC, 1'b0, typ));
      chk("R8 sel kept", tr_sel, s0);
      chk("R8 base kept", tr_base, {32'h0, b0[31:0]});
    end

    // R6 table indicator
    put_desc(3, 64'h0, 20'h1, 1'b0, 5'b01001);
    run_load(16'h001C, 1'b0, 1'b0);
    chk("R6 fault", {got_done, got_fault}, 2'b01);
    chk("R6 no access", n_rd + n_wr, 0);
    chk("R6 sel kept", tr_sel, 16'h0020);

    // R7 table limit boundary
    gdt_limit = 16'd47;
    put_desc(5, 64'h0000_0000_0A0B_0C0D, 20'h00055, 1'b0, 5'b01001);
    run_load(16'h0028, 1'b0, 1'b0);
    chk("R7 legacy edge ok", {got_done, got_fault}, 2'b10);
    gdt_limit = 16'd46;
    put_desc(5, 64'h0, 20'h00055, 1'b0, 5'b01001);
    run_load(16'h0028, 1'b0, 1'b0);
    chk("R7 legacy past edge", {got_done, got_fault, 1'(n_rd)}, 3'b010);
    chk("R7 sel kept", tr_sel, 16'h0028);
    put_desc(4, 64'h0, 20'h00066, 1'b0, 5'b01001);
    run_load(16'h0020, 1'b1, 1'b0);
    chk("R7 long past edge", {got_done, got_fault, 1'(n_rd)}, 3'b010);
    run_load(16'h0020, 1'b0, 1'b0);
    chk("R7 legacy same idx ok", {got_done, got_fault}, 2'b10);
    put_desc(4, 64'h0, 20'h00066, 1'b0, 5'b01001);
    gdt_limit = 16'd47;
    run_load(16'h0020, 1'b1, 1'b0);
    chk("R7 long edge ok", {got_done, got_fault, 3'(n_rd)}, 5'b10100);
    gdt_limit = 16'h00FF;

    // R12 request while busy
    slow = 1'b1;
    put_desc(12, 64'h0, 20'h00777, 1'b0, 5'b01001);
    put_desc(13, 64'h0, 20'h00888, 1'b0, 5'b01001);
    run_load(16'h0060, 1'b0, 1'b1);
    chk("R12 first wins", tr_sel, 16'h0060);
    chk("R12 reads", n_rd, 2);
    chk("R12 other untouched", mem[27], mk_w1(64'h0, 20'h00888, 1'b0, 5'b01001));
    repeat (10) @(negedge clk);
    chk("R12 idle", {ld_busy, mem_valid}, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule